// File: doc/BRIEF.md
# Eight-Lane Vector Add/Subtract with Chained Carry Flags

This block adds or subtracts two vectors of eight 16-bit lanes and keeps a 16-bit flag register that links one operation to the next. Two opcodes produce a per-lane carry (for addition) or borrow (for subtraction), together with a per-lane flag that records whether the two operands differed. Both results are written into the flag register.

The other two opcodes are a plain add and a plain subtract. These fold the stored carry or borrow of each lane into that lane's result, and then clear the whole flag register. Software forms 32-bit arithmetic from two 16-bit steps. It issues the carry-producing operation on the low halves and then the plain operation on the high halves.

An operation is accepted on a clock edge where the valid strobe is high. The result vector and the flag register both update on that edge and hold their values until the next accepted operation.

Top module: `vcarry_addsub`

## Requirements
- R1: After reset, the result output and the flag output are all zeros.
- R2: Opcode 0 (plain add) returns, for each lane i, vs + vt + flags[i], wrapped modulo 2^16.
- R3: Opcode 1 (plain subtract) returns, for each lane i, vs - vt - flags[i], wrapped modulo 2^16.
- R4: Opcode 2 (add with carry out) returns vs + vt modulo 2^16 in each lane, ignoring the stored flags, and sets flags[i] to that lane's carry out of bit 15.
- R5: Opcode 3 (subtract with borrow out) returns vs - vt modulo 2^16 in each lane, ignoring the stored flags, and sets flags[i] to 1 exactly when vs < vt as unsigned numbers.
- R6: Opcodes 2 and 3 set flags[8+i] to 1 when lane i's two operands differ, and to 0 when they are equal.
- R7: Opcodes 0 and 1 clear all 16 flag bits on the edge that accepts them.
- R8: While valid is low, the result output and the flag output keep their values whatever the operand and opcode inputs do.
- R9: An opcode 2 on the low halves followed by an opcode 0 on the high halves yields the 32-bit sum modulo 2^32 in each lane. Opcode 3 followed by opcode 1 yields the 32-bit difference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Accept the operation on this edge |
| op_i | input | 2 | 0 add, 1 sub, 2 add with carry out, 3 sub with borrow out |
| vs_i | input | 128 | First operand; lane i in bits 16i+15:16i |
| vt_i | input | 128 | Second operand, same lane layout |
| res_o | output | 128 | Registered result vector |
| flags_o | output | 16 | Flag register: bits 7:0 carry/borrow, bits 15:8 not-equal |

## Verification
Both the result vector and the flag register change on the same edge that samples valid_i high, so each result is due one edge after the stimulus is applied. The bench drives inputs on the falling edge. The rising edge then accepts the operation, and the bench compares outputs at the following falling edge against a model of its own. That model tracks the flag register and applies it to the next operation. Idle cycles are checked the same way: the bench changes the inputs with valid low, waits one edge, and expects no change.

// File: rtl/vcarry_pkg.sv
package vcarry_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_SUB  = 2'd1,
    OP_ADDC = 2'd2,
    OP_SUBC = 2'd3
  } op_e;
endpackage

// File: rtl/vcarry_lane.sv
module vcarry_lane
  import vcarry_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  op_e          op_i,
  output logic [W-1:0] res_o,
  output logic         co_o,
  output logic         ne_o
);
  logic [W:0] a_x, b_x, c_x, sum;

  assign a_x = {1'b0, a_i};
  assign b_x = {1'b0, b_i};
  assign c_x = {{W{1'b0}}, cin_i};

  // bit W of the 17-bit result is carry for add, borrow for sub
  always_comb begin
    unique case (op_i)
      OP_ADD:  sum = a_x + b_x + c_x;
      OP_SUB:  sum = a_x - b_x - c_x;
      OP_ADDC: sum = a_x + b_x;
      OP_SUBC: sum = a_x - b_x;
      default: sum = '0;
    endcase
  end

  assign res_o = sum[W-1:0];
  assign co_o  = sum[W];
  assign ne_o  = (a_i != b_i);
endmodule

// File: rtl/vcarry_flags.sv
module vcarry_flags #(
  parameter int LANES = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               upd_i,
  input  logic               clr_i,
  input  logic [LANES-1:0]   co_i,
  input  logic [LANES-1:0]   ne_i,
  output logic [2*LANES-1:0] flags_o
);
  logic [2*LANES-1:0] flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flags_q <= '0;
    else if (upd_i) flags_q <= {ne_i, co_i};
    else if (clr_i) flags_q <= '0;
  end

  assign flags_o = flags_q;

  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !upd_i |=> flags_o == '0);
  p_hold_flags_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i && !clr_i |=> $stable(flags_o));
  p_excl_ops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(upd_i && clr_i));
endmodule

// File: rtl/vcarry_addsub.sv
module vcarry_addsub
  import vcarry_pkg::*;
#(
  parameter int LANES = 8,
  parameter int W     = 16,
  localparam int VW   = LANES * W,
  localparam int FW   = 2 * LANES
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [1:0]    op_i,
  input  logic [VW-1:0] vs_i,
  input  logic [VW-1:0] vt_i,
  output logic [VW-1:0] res_o,
  output logic [FW-1:0] flags_o
);
  op_e              op;
  logic [VW-1:0]    res_d;
  logic [VW-1:0]    res_q;
  logic [LANES-1:0] co, ne;
  logic             carry_op;

  assign op       = op_e'(op_i);
  assign carry_op = (op == OP_ADDC) || (op == OP_SUBC);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    vcarry_lane #(.W(W)) u_lane (
      .a_i  (vs_i[i*W +: W]),
      .b_i  (vt_i[i*W +: W]),
      .cin_i(flags_o[i]),
      .op_i (op),
      .res_o(res_d[i*W +: W]),
      .co_o (co[i]),
      .ne_o (ne[i])
    );

    p_ne_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i && carry_op |=>
        flags_o[LANES+i] == ($past(vs_i[i*W +: W]) != $past(vt_i[i*W +: W])));
    p_borrow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i && op == OP_SUBC && (vs_i[i*W +: W] < vt_i[i*W +: W]) |=> flags_o[i]);
  end

  vcarry_flags #(.LANES(LANES)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (valid_i && carry_op),
    .clr_i  (valid_i && !carry_op),
    .co_i   (co),
    .ne_i   (ne),
    .flags_o(flags_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      res_q <= '0;
    else if (valid_i) res_q <= res_d;
  end

  assign res_o = res_q;

  p_hold_res_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(res_o));
  p_subc_equal_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op == OP_SUBC && vs_i == vt_i |=> res_o == '0 && flags_o == '0);
  p_plain_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !carry_op |=> flags_o == '0);
endmodule

// File: tb/vcarry_addsub_tb.sv
module vcarry_addsub_tb;
  localparam int LANES = 8;
  localparam int W     = 16;
  localparam int VW    = LANES * W;
  localparam int FW    = 2 * LANES;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [1:0]    op_i = '0;
  logic [VW-1:0] vs_i = '0, vt_i = '0;
  logic [VW-1:0] res_o;
  logic [FW-1:0] flags_o;

  int checks = 0, errors = 0;
  logic [FW-1:0] m_flags = '0;
  logic [31:0]   seed = 32'h1234_5678;
  logic [VW-1:0] last_res;

  always #5 clk_i = ~clk_i;

  vcarry_addsub u_dut (.*);

  function automatic logic [31:0] rnd32(ref logic [31:0] s);
    s = s * 32'd1664525 + 32'd1013904223;
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input logic [VW-1:0] act,
                       input logic [VW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, accepted on next posedge, checked on the following negedge
  task automatic run_op(input logic [1:0] op, input logic [VW-1:0] a, input logic [VW-1:0] b);
    logic [VW-1:0] e_res;
    logic [FW-1:0] e_flags;
    string req;
    e_flags = '0;
    for (int i = 0; i < LANES; i++) begin
      logic [16:0] x, y, c, s;
      x = {1'b0, a[i*W +: W]};
      y = {1'b0, b[i*W +: W]};
      c = {16'd0, m_flags[i]};
      case (op)
        2'd0: s = x + y + c;
        2'd1: s = x - y - c;
        2'd2: s = x + y;
        default: s = x - y;
      endcase
      e_res[i*W +: W] = s[15:0];
      if (op == 2'd2) e_flags[i] = s[16];
      if (op == 2'd3) e_flags[i] = (x < y);
      if (op[1]) e_flags[LANES+i] = (x != y);
    end
    req = (op == 2'd0) ? "R2" : (op == 2'd1) ? "R3" : (op == 2'd2) ? "R4" : "R5";
    @(negedge clk_i);
    valid_i = 1'b1; op_i = op; vs_i = a; vt_i = b;
    @(negedge clk_i);
    valid_i = 1'b0;
    m_flags = e_flags;
    check(res_o === e_res, req, res_o, e_res);
    check(flags_o === e_flags, op[1] ? "R6 flags" : "R7 flags",
          {{(VW-FW){1'b0}}, flags_o}, {{(VW-FW){1'b0}}, e_flags});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [15:0] corner [5];
    logic [VW-1:0] a, b;
    corner[0] = 16'h0000; corner[1] = 16'hFFFF; corner[2] = 16'h8000;
    corner[3] = 16'h0001; corner[4] = 16'h7FFF;

    #1;
    check(res_o === '0 && flags_o === '0, "R1 reset", res_o, '0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(res_o === '0 && flags_o === '0, "R1 after release", res_o, '0);

    // corner sweep: every op over all corner pairings, rotated per lane
    for (int op = 0; op < 4; op++)
      for (int p = 0; p < 5; p++)
        for (int q = 0; q < 5; q++) begin
          for (int i = 0; i < LANES; i++) begin
            a[i*W +: W] = corner[(p + i) % 5];
            b[i*W +: W] = corner[(q + 2*i) % 5];
          end
          run_op(2'd3, b, a);     // preload flags so plain ops see carries
          run_op(op[1:0], a, b);
        end

    // random sweep with random op sequence
    for (int n = 0; n < 600; n++) begin
      for (int i = 0; i < LANES; i++) begin
        a[i*W +: W] = rnd32(seed) >> 8;
        b[i*W +: W] = rnd32(seed) >> 8;
        if ((rnd32(seed) & 32'h7) == 0) b[i*W +: W] = a[i*W +: W];
      end
      run_op(rnd32(seed) >> 30, a, b);
    end

    // R8: inputs move with valid low; nothing changes
    run_op(2'd2, {LANES{16'hF00F}}, {LANES{16'h1FF1}});
    last_res = res_o;
    begin
      logic [FW-1:0] f0;
      f0 = flags_o;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk_i);
        op_i = k[1:0]; vs_i = {4{rnd32(seed)}}; vt_i = {4{rnd32(seed)}};
        @(negedge clk_i);
        check(res_o === last_res, "R8 result held", res_o, last_res);
        check(flags_o === f0, "R8 flags held", {{(VW-FW){1'b0}}, flags_o},
              {{(VW-FW){1'b0}}, f0});
      end
    end

    // R9: 32-bit chained add and subtract per lane
    for (int n = 0; n < 40; n++) begin
      logic [31:0] x [LANES], y [LANES];
      logic [VW-1:0] lo, hi, e;
      for (int i = 0; i < LANES; i++) begin
        x[i] = rnd32(seed); y[i] = rnd32(seed);
        if (n == 0) begin x[i] = 32'h0000_FFFF; y[i] = 32'h0000_0001; end
        if (n == 1) begin x[i] = 32'h0001_0000; y[i] = 32'h0000_0001; end
      end
      for (int s = 0; s < 2; s++) begin
        for (int i = 0; i < LANES; i++) begin
          a[i*W +: W] = x[i][15:0]; b[i*W +: W] = y[i][15:0];
        end
        run_op(s ? 2'd3 : 2'd2, a, b);
        lo = res_o;
        for (int i = 0; i < LANES; i++) begin
          a[i*W +: W] = x[i][31:16]; b[i*W +: W] = y[i][31:16];
        end
        run_op(s ? 2'd1 : 2'd0, a, b);
        hi = res_o;
        for (int i = 0; i < LANES; i++) begin
          logic [31:0] r;
          r = s ? x[i] - y[i] : x[i] + y[i];
          e[i*W +: W] = r[31:16];
          check({hi[i*W +: W], lo[i*W +: W]} === r, "R9 chained 32-bit",
                {{(VW-32){1'b0}}, hi[i*W +: W], lo[i*W +: W]}, {{(VW-32){1'b0}}, r});
        end
        check(hi === e, "R9 high halves", hi, e);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule